// File: doc/BRIEF.md
# Processor interrupt delivery controller

This block sits between the interrupt sources of a system and a single processor core. It takes a reset request, a non-maskable interrupt (NMI) request and a six-bit maskable interrupt level. It holds each request as pending until the core can take it. It also maintains the hardware-interrupt pending field of the core's cause register. Evaluation happens only on cycles where the core signals an instruction boundary. On such a cycle the block picks the most urgent pending request and may raise a one-cycle exception request. An exception code tells the core whether the request is a combined reset/NMI entry or an ordinary interrupt.

Maskable interrupts are gated by the core's status register: a global enable bit and a six-bit mask field, both sampled on the evaluation cycle. A masked or disabled level is not lost. It stays pending and is checked again at every later instruction boundary until it is delivered or its source withdraws it. A withdrawal is a level update of zero. It is held as a distinct "cleared" state, and evaluating that state wipes the cause pending field without raising an exception.

Top module: `irq_deliver_ctrl`

## Requirements
- R1: During and directly after synchronous reset, `exc_req_o`, `exc_code_o` and `cause_ip_o` are all zero.
- R2: A rising edge on `rst_req_i` or `nmi_req_i` latches a pending flag one clock later. A request input held high yields exactly one exception request, and a falling edge has no effect.
- R3: At most one request is serviced per evaluation. The priority is a pending reset first, then a pending NMI, then the maskable level.
- R4: Servicing a reset or an NMI raises `exc_req_o` with `exc_code_o` = 1 (reset/NMI entry). It clears only the flag of the request serviced and leaves `cause_ip_o` unchanged.
- R5: Whenever `lvl_i` differs from its value on the previous clock, the new value is captured and replaces any earlier unserviced level.
- R6: Evaluating a pending nonzero level loads `cause_ip_o` with the level bits. Bit i of the level maps to bit i of the cause pending field.
- R7: A pending level is delivered (`exc_req_o` = 1, `exc_code_o` = 0) only when `sr_ie_i` is 1 and (level AND `sr_im_i`) is nonzero. After delivery the level is no longer pending and produces no further request.
- R8: A level that is masked or disabled when evaluated stays pending. It is evaluated again at every later instruction boundary and is delivered once the status register allows it.
- R9: A level update of zero is held as a cleared state. Evaluating it sets `cause_ip_o` to zero and raises no exception, and a level pending before the withdrawal is dropped.
- R10: Evaluation takes place only at clock edges where `insn_bound_i` is 1. Outputs are registered, so results appear after that edge, and `exc_req_o` stays high for one cycle per evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request from the system, rising-edge sensitive |
| nmi_req_i | input | 1 | Non-maskable interrupt request, rising-edge sensitive |
| lvl_i | input | IP_W (6) | Maskable interrupt level, zero means withdrawn |
| insn_bound_i | input | 1 | Instruction boundary strobe from the core, enables evaluation |
| sr_ie_i | input | 1 | Status register global interrupt enable |
| sr_im_i | input | IP_W (6) | Status register interrupt mask field |
| exc_req_o | output | 1 | One-cycle exception request to the core |
| exc_code_o | output | 1 | 1 = reset/NMI entry, 0 = ordinary interrupt |
| cause_ip_o | output | IP_W (6) | Cause register hardware-interrupt pending field |

## Verification
The delivery rule is swept over every nonzero level, every mask value and both enable states. Each combination shows whether the enable-and-mask gate decides delivery correctly, whether the cause field follows the level, and whether a blocked level survives until it is unmasked. Simultaneous reset, NMI and level events separate the priority order and show that each service clears only its own flag. Sequences with the strobe held low, a held-high request, two level updates before one evaluation, and a withdrawal while masked separate the edge capture, the strobe gating, the overwrite rule and the cleared state.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  // state of the maskable level slot
  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_PEND = 2'd1,
    LV_CLR  = 2'd2
  } lvl_st_e;

  // exception code driven to the core
  localparam logic EXC_RSTNMI = 1'b1;
  localparam logic EXC_INT    = 1'b0;
endpackage

// File: rtl/irqd_edge_flag.sv
module irqd_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = req_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= req_i;
      // a fresh edge wins over a clear in the same cycle
      pend_o <= rise | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/irqd_level_track.sv
module irqd_level_track #(
  parameter int IP_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IP_W-1:0]      lvl_i,
  input  logic                 consume_i,
  output irqd_pkg::lvl_st_e    state_o,
  output logic [IP_W-1:0]      lvl_o
);
  import irqd_pkg::*;

  logic [IP_W-1:0] prev_q;
  logic            changed;

  assign changed = (lvl_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      lvl_o   <= '0;
      state_o <= LV_IDLE;
    end else begin
      prev_q <= lvl_i;
      if (changed) begin
        lvl_o   <= lvl_i;
        state_o <= (lvl_i == '0) ? LV_CLR : LV_PEND;
      end else if (consume_i) begin
        state_o <= LV_IDLE;
      end
    end
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int IP_W = 6
) (
  input  logic              eval_i,
  input  logic              pend_rst_i,
  input  logic              pend_nmi_i,
  input  irqd_pkg::lvl_st_e lvl_st_i,
  input  logic [IP_W-1:0]   lvl_i,
  input  logic              sr_ie_i,
  input  logic [IP_W-1:0]   sr_im_i,
  output logic              clr_rst_o,
  output logic              clr_nmi_o,
  output logic              consume_o,
  output logic              fire_o,
  output logic              code_o,
  output logic              ip_load_o,
  output logic [IP_W-1:0]   ip_val_o
);
  import irqd_pkg::*;

  logic unmasked;
  assign unmasked = sr_ie_i & (|(lvl_i & sr_im_i));

  always_comb begin
    clr_rst_o = 1'b0;
    clr_nmi_o = 1'b0;
    consume_o = 1'b0;
    fire_o    = 1'b0;
    code_o    = EXC_INT;
    ip_load_o = 1'b0;
    ip_val_o  = '0;
    if (eval_i) begin
      if (pend_rst_i) begin
        fire_o    = 1'b1;
        code_o    = EXC_RSTNMI;
        clr_rst_o = 1'b1;
      end else if (pend_nmi_i) begin
        fire_o    = 1'b1;
        code_o    = EXC_RSTNMI;
        clr_nmi_o = 1'b1;
      end else if (lvl_st_i == LV_PEND) begin
        ip_load_o = 1'b1;
        ip_val_o  = lvl_i;
        if (unmasked) begin
          fire_o    = 1'b1;
          consume_o = 1'b1;
        end
      end else if (lvl_st_i == LV_CLR) begin
        ip_load_o = 1'b1;
        consume_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_deliver_ctrl.sv
module irq_deliver_ctrl #(
  parameter int IP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_req_i,
  input  logic            nmi_req_i,
  input  logic [IP_W-1:0] lvl_i,
  input  logic            insn_bound_i,
  input  logic            sr_ie_i,
  input  logic [IP_W-1:0] sr_im_i,
  output logic            exc_req_o,
  output logic            exc_code_o,
  output logic [IP_W-1:0] cause_ip_o
);
  import irqd_pkg::*;

  localparam int NSRC = 2; // edge-sensitive sources: 0 reset, 1 NMI

  logic [NSRC-1:0] src_req, src_pend, src_clr;
  lvl_st_e         lvl_st;
  logic [IP_W-1:0] lvl_val, ip_val;
  logic            consume, fire, code, ip_load;

  assign src_req = {nmi_req_i, rst_req_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqd_edge_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .req_i  (src_req[g]),
      .clr_i  (src_clr[g]),
      .pend_o (src_pend[g])
    );
  end

  irqd_level_track #(.IP_W(IP_W)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl_i),
    .consume_i (consume),
    .state_o   (lvl_st),
    .lvl_o     (lvl_val)
  );

  irqd_arbiter #(.IP_W(IP_W)) u_arb (
    .eval_i     (insn_bound_i),
    .pend_rst_i (src_pend[0]),
    .pend_nmi_i (src_pend[1]),
    .lvl_st_i   (lvl_st),
    .lvl_i      (lvl_val),
    .sr_ie_i    (sr_ie_i),
    .sr_im_i    (sr_im_i),
    .clr_rst_o  (src_clr[0]),
    .clr_nmi_o  (src_clr[1]),
    .consume_o  (consume),
    .fire_o     (fire),
    .code_o     (code),
    .ip_load_o  (ip_load),
    .ip_val_o   (ip_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req_o  <= 1'b0;
      exc_code_o <= 1'b0;
      cause_ip_o <= '0;
    end else begin
      exc_req_o  <= fire;
      exc_code_o <= fire & code;
      if (ip_load) cause_ip_o <= ip_val;
    end
  end
endmodule

// File: rtl/irqd_checks.sv
module irqd_checks #(
  parameter int IP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            insn_bound_i,
  input logic            sr_ie_i,
  input logic [IP_W-1:0] sr_im_i,
  input logic            exc_req_o,
  input logic            exc_code_o,
  input logic [IP_W-1:0] cause_ip_o
);
  // R10: a request only follows an evaluation edge
  a_r10_req_after_strobe: assert property (@(posedge clk) disable iff (rst)
    exc_req_o |-> $past(insn_bound_i));

  // R10: the cause field only moves after an evaluation edge
  a_r10_cause_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(insn_bound_i) |-> $stable(cause_ip_o));

  // R7: an ordinary interrupt needs the enable and an unmasked bit
  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    (exc_req_o && !exc_code_o) |-> ($past(sr_ie_i) && ((cause_ip_o & $past(sr_im_i)) != '0)));

  // R9: no ordinary interrupt with an empty cause field
  a_r9_no_int_when_clear: assert property (@(posedge clk) disable iff (rst)
    (exc_req_o && !exc_code_o) |-> (cause_ip_o != '0));

  // R4: the code is only set together with a request
  a_r4_code_with_req: assert property (@(posedge clk) disable iff (rst)
    exc_code_o |-> exc_req_o);
endmodule

bind irq_deliver_ctrl irqd_checks #(.IP_W(IP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .insn_bound_i (insn_bound_i),
  .sr_ie_i      (sr_ie_i),
  .sr_im_i      (sr_im_i),
  .exc_req_o    (exc_req_o),
  .exc_code_o   (exc_code_o),
  .cause_ip_o   (cause_ip_o)
);

// File: tb/sim_irq_deliver_ctrl.sv
module sim_irq_deliver_ctrl;
  localparam int IP_W = 6;
  localparam time PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rst_req = 1'b0, nmi_req = 1'b0, strobe = 1'b0, ie = 1'b0;
  logic [IP_W-1:0] lvl = '0, im = '0;
  logic            req, code;
  logic [IP_W-1:0] cause;
  int              checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_deliver_ctrl #(.IP_W(IP_W)) u0 (
    .clk(clk), .rst(rst), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
    .lvl_i(lvl), .insn_bound_i(strobe), .sr_ie_i(ie), .sr_im_i(im),
    .exc_req_o(req), .exc_code_o(code), .cause_ip_o(cause)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 req in reset", int'(req), 0);
    check("R1 cause in reset", int'(cause), 0);
    rst = 1'b0;
    tick();
    check("R1 req after reset", int'(req), 0);
    check("R1 code after reset", int'(code), 0);
    check("R1 cause after reset", int'(cause), 0);

    // R3 / R4: all three sources at once
    ie = 1'b1; im = '1;
    rst_req = 1'b1; nmi_req = 1'b1; lvl = 6'd5;
    tick();
    strobe = 1'b1;
    tick();
    check("R3 reset first req", int'(req), 1);
    check("R4 reset code", int'(code), 1);
    check("R4 cause kept on reset", int'(cause), 0);
    tick();
    check("R3 nmi second req", int'(req), 1);
    check("R4 nmi code", int'(code), 1);
    tick();
    check("R3 level third req", int'(req), 1);
    check("R3 level code", int'(code), 0);
    check("R6 level cause", int'(cause), 5);
    tick();
    check("R2 held request gives one pulse", int'(req), 0);
    rst_req = 1'b0; nmi_req = 1'b0;
    tick();
    check("R2 falling edge ignored", int'(req), 0);

    // R10: strobe low blocks evaluation
    strobe = 1'b0;
    nmi_req = 1'b1;
    tick(); tick(); tick();
    check("R10 no eval without strobe", int'(req), 0);
    strobe = 1'b1;
    tick();
    check("R10 eval on strobe", int'(req), 1);
    check("R10 eval code", int'(code), 1);
    tick();
    check("R10 one cycle pulse", int'(req), 0);
    nmi_req = 1'b0;

    // R5 overwrite, R8 masked, R9 withdrawal while masked
    strobe = 1'b0; ie = 1'b0; im = '0;
    lvl = 6'd3; tick();
    lvl = 6'd12; tick();
    strobe = 1'b1;
    tick();
    check("R5 latest level in cause", int'(cause), 12);
    check("R8 masked no req", int'(req), 0);
    lvl = 6'd0;
    tick();
    tick();
    check("R9 cause wiped", int'(cause), 0);
    check("R9 no req on clear", int'(req), 0);
    ie = 1'b1; im = '1;
    tick();
    check("R9 withdrawn level dropped", int'(req), 0);
    strobe = 1'b0;

    // sweep: every level, every mask, both enables
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < (1 << IP_W); m++) begin
        for (int l = 1; l < (1 << IP_W); l++) begin
          bit exp;
          strobe = 1'b0; lvl = '0;
          tick();
          strobe = 1'b1;
          tick();
          check("R9 sweep clear cause", int'(cause), 0);
          check("R9 sweep clear req", int'(req), 0);
          strobe = 1'b0;
          ie = e[0]; im = m[IP_W-1:0]; lvl = l[IP_W-1:0];
          tick();
          strobe = 1'b1;
          tick();
          exp = (e != 0) && ((l & m) != 0);
          check("R7 sweep delivery", int'(req), int'(exp));
          check("R6 sweep cause", int'(cause), l);
          if (exp) check("R7 sweep code", int'(code), 0);
          if (!exp) begin
            tick();
            check("R8 still masked", int'(req), 0);
            check("R8 cause kept", int'(cause), l);
            ie = 1'b1; im = '1;
            tick();
            check("R8 delivered after unmask", int'(req), 1);
          end
          tick();
          check("R7 no repeat after delivery", int'(req), 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule